// File: doc/BRIEF.md
# Linked Buffer Descriptor Fetcher

This block walks a linked chain of buffer descriptors held in memory and turns each one into a single transfer command for a serial engine. Every descriptor is four 32-bit words at consecutive addresses: a control word, a status word that the block reads but does not use, the payload buffer address, and the address of the next descriptor. The block reads the four words through a simple request/response memory port. It checks the control word and presents one command. It then waits for the engine's done pulse and follows the next pointer.

Software loads a base-address register and writes the control register to start the walk. It observes progress through a current-address output and three single-cycle event outputs: descriptor done, packet complete and error. Writing the control register with its enable bit clear stops the walk at once. Moving the payload is the serial engine's job and lies outside this block.

Top module: `bd_chain_walker`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_req`, `cmd_valid` and all event outputs are 0 and `cur_addr` is 0.
- R2: A control write with `ctl_wdata` = 3'b111 (bit 0 enable, bit 1 poll, bit 2 start) starts a walk at the base-address register. Any other control write with bit 0 set does nothing. Each descriptor is read as four requests at its address plus 0, 4, 8 and 12, and `cur_addr` equals that descriptor's address.
- R3: The control word maps to the command as follows. Bits 8:0 give `cmd_len`, bit 20 gives `cmd_rx`, bit 21 gives `cmd_ddr`, bit 25 gives `cmd_lsb_first`, bit 27 gives `cmd_poll`, bits 29:28 give `cmd_cs` and bit 30 gives `cmd_cs_release`. `cmd_lanes` is 2'b10 when bit 23 is set, otherwise 2'b01 when bit 22 is set, otherwise 2'b00. `cmd_buf_addr` is descriptor word 2.
- R4: A descriptor whose control bit 31 (hardware-owned) is clear produces one `ev_err` pulse and no command, and the block returns to idle.
- R5: A descriptor whose length field exceeds 256 is treated like R4: one `ev_err` pulse, no command, idle.
- R6: After `eng_done` for a descriptor, `ev_bd_done` pulses once if control bit 16 is set. `ev_err` never coincides with `ev_bd_done` or `ev_pkt_done`.
- R7: After `eng_done`, `ev_pkt_done` pulses once only if control bits 17 and 18 are both set.
- R8: After `eng_done`, if bit 19 is clear and word 3 is nonzero, the block fetches the descriptor at word 3 and `cur_addr` takes that value.
- R9: A next pointer of zero ends the walk; the block returns to idle.
- R10: After a descriptor with bit 19 set completes, the block returns to idle and does not read its next pointer target.
- R11: A control write with bit 0 clear moves the block to idle on the next cycle, drops `cmd_valid`, and no command from the abandoned descriptor is accepted later.
- R12: `cmd_valid` and the command fields stay constant until `cmd_ready` is seen; each descriptor gives exactly one accepted command.
- R13: A start write while the block is busy is ignored; only the walk already running completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control value: bit 0 enable, bit 1 poll, bit 2 start |
| base_wr | input | 1 | Base-address register write strobe |
| base_wdata | input | AW | Address of the first descriptor |
| cur_addr | output | AW | Address of the descriptor being processed |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Command offered to the serial engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_len | output | 9 | Transfer length in bytes |
| cmd_rx | output | 1 | 1 = receive, 0 = transmit |
| cmd_ddr | output | 1 | Double data rate |
| cmd_lanes | output | 2 | 00 single, 01 dual, 10 quad |
| cmd_lsb_first | output | 1 | Least significant bit first |
| cmd_poll | output | 1 | Status-poll transfer |
| cmd_cs | output | 2 | Device select |
| cmd_cs_release | output | 1 | Release chip select after this transfer |
| cmd_buf_addr | output | AW | Payload buffer address |
| eng_done | input | 1 | Engine finished the accepted command |
| ev_bd_done | output | 1 | Descriptor-complete event pulse |
| ev_pkt_done | output | 1 | Packet-complete event pulse |
| ev_err | output | 1 | Descriptor error event pulse |

## Verification
The assertions check on every cycle that a stalled command holds steady, that a stop write always lands in idle, that an error pulse never coincides with an offered command or a completion event, and that a final or null-terminated descriptor ends the walk. Only the bench scenarios can show that the control-word fields decode to the right command values and that a chain is walked in the right order with the right fetch addresses. They also show that an unowned or oversized descriptor produces no command, and that the right number of completion events appears over a whole chain.

// File: rtl/bdw_pkg.sv
package bdw_pkg;

  localparam int DESC_WORDS = 4;
  localparam int WORD_W     = 32;

  localparam int W_CTRL = 0;
  localparam int W_STAT = 1;
  localparam int W_BUF  = 2;
  localparam int W_NEXT = 3;

  localparam int B_IE_BD   = 16;
  localparam int B_IE_PKT  = 17;
  localparam int B_PKT_END = 18;
  localparam int B_LAST    = 19;
  localparam int B_RX      = 20;
  localparam int B_DDR     = 21;
  localparam int B_DUAL    = 22;
  localparam int B_QUAD    = 23;
  localparam int B_LSB     = 25;
  localparam int B_POLL    = 27;
  localparam int B_CS_LO   = 28;
  localparam int B_CS_REL  = 30;
  localparam int B_OWNED   = 31;

  localparam int LEN_W = 9;

  typedef struct packed {
    logic             cs_release;
    logic [1:0]       cs;
    logic             poll;
    logic             lsb_first;
    logic [1:0]       lanes;
    logic             ddr;
    logic             rx;
    logic [LEN_W-1:0] len;
  } bdw_cmd_t;

  typedef struct packed {
    logic owned;
    logic last;
    logic pkt_end;
    logic ie_bd;
    logic ie_pkt;
  } bdw_flags_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_CHECK,
    S_ISSUE,
    S_WAIT
  } bdw_state_t;

endpackage

// File: rtl/bdw_fetch.sv
module bdw_fetch #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic                abort,
  input  logic [AW-1:0]       start_addr,
  output logic                mem_req,
  output logic [AW-1:0]       mem_addr,
  input  logic                mem_rvalid,
  input  logic [DW-1:0]       mem_rdata,
  output logic [WORDS*DW-1:0] words,
  output logic                done
);

  localparam int IW    = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int BYTES = DW / 8;
  localparam logic [IW-1:0] LAST_IDX = IW'(WORDS - 1);

  logic [IW-1:0] idx;
  logic          active;
  logic [DW-1:0] wbuf [WORDS];

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      active   <= 1'b0;
      mem_req  <= 1'b0;
      done     <= 1'b0;
      idx      <= '0;
      mem_addr <= '0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      if (go) begin
        active   <= 1'b1;
        idx      <= '0;
        mem_req  <= 1'b1;
        mem_addr <= start_addr;
      end else if (active && mem_rvalid) begin
        if (idx == LAST_IDX) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          idx      <= idx + 1'b1;
          mem_req  <= 1'b1;
          mem_addr <= mem_addr + AW'(BYTES);
        end
      end
    end
  end

  // Word store kept free of reset so it maps onto plain registers or RAM.
  always_ff @(posedge clk) begin
    if (active && mem_rvalid)
      wbuf[idx] <= mem_rdata;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_pack
    assign words[g*DW +: DW] = wbuf[g];
  end

endmodule

// File: rtl/bdw_decode.sv
module bdw_decode
  import bdw_pkg::*;
#(
  parameter int LEN_MAX = 256
) (
  input  logic [WORD_W-1:0] ctrl_word,
  output bdw_cmd_t          cmd,
  output bdw_flags_t        flags,
  output logic              len_bad
);

  localparam logic [LEN_W-1:0] LMAX = LEN_W'(LEN_MAX);

  always_comb begin
    cmd.len        = ctrl_word[LEN_W-1:0];
    cmd.rx         = ctrl_word[B_RX];
    cmd.ddr        = ctrl_word[B_DDR];
    cmd.lsb_first  = ctrl_word[B_LSB];
    cmd.poll       = ctrl_word[B_POLL];
    cmd.cs         = ctrl_word[B_CS_LO +: 2];
    cmd.cs_release = ctrl_word[B_CS_REL];
    if (ctrl_word[B_QUAD])      cmd.lanes = 2'b10;
    else if (ctrl_word[B_DUAL]) cmd.lanes = 2'b01;
    else                        cmd.lanes = 2'b00;

    flags.owned   = ctrl_word[B_OWNED];
    flags.last    = ctrl_word[B_LAST];
    flags.pkt_end = ctrl_word[B_PKT_END];
    flags.ie_bd   = ctrl_word[B_IE_BD];
    flags.ie_pkt  = ctrl_word[B_IE_PKT];
  end

  assign len_bad = (ctrl_word[LEN_W-1:0] > LMAX);

  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^{ctrl_word[15:LEN_W], ctrl_word[24], ctrl_word[26]};

endmodule

// File: rtl/bdw_seq.sv
module bdw_seq
  import bdw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [2:0]        ctl_wdata,
  input  logic [AW-1:0]     base_addr,
  input  logic              fetch_done,
  input  bdw_cmd_t          dec_cmd,
  input  bdw_flags_t        dec_flags,
  input  logic              dec_len_bad,
  input  logic [WORD_W-1:0] buf_word,
  input  logic [WORD_W-1:0] next_word,
  input  logic              cmd_ready,
  input  logic              eng_done,
  output logic              fetch_go,
  output logic              fetch_abort,
  output logic [AW-1:0]     cur_addr,
  output logic              busy,
  output logic              cmd_valid,
  output bdw_cmd_t          cmd_q,
  output logic [AW-1:0]     cmd_addr,
  output logic              ev_bd_done,
  output logic              ev_pkt_done,
  output logic              ev_err
);

  bdw_state_t    state;
  logic [AW-1:0] next_q;
  logic          last_q;
  logic          bd_ie_q;
  logic          pkt_q;
  logic          start_req;
  logic          stop_req;

  assign start_req   = ctl_wr && (ctl_wdata == 3'b111);
  assign stop_req    = ctl_wr && !ctl_wdata[0];
  assign fetch_abort = stop_req;
  assign busy        = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      cur_addr    <= '0;
      fetch_go    <= 1'b0;
      cmd_valid   <= 1'b0;
      cmd_q       <= '0;
      cmd_addr    <= '0;
      next_q      <= '0;
      last_q      <= 1'b0;
      bd_ie_q     <= 1'b0;
      pkt_q       <= 1'b0;
      ev_bd_done  <= 1'b0;
      ev_pkt_done <= 1'b0;
      ev_err      <= 1'b0;
    end else begin
      fetch_go    <= 1'b0;
      ev_bd_done  <= 1'b0;
      ev_pkt_done <= 1'b0;
      ev_err      <= 1'b0;
      if (stop_req) begin
        state     <= S_IDLE;
        cmd_valid <= 1'b0;
      end else begin
        case (state)
          S_IDLE: begin
            if (start_req) begin
              cur_addr <= base_addr;
              fetch_go <= 1'b1;
              state    <= S_FETCH;
            end
          end
          S_FETCH: begin
            if (fetch_done) state <= S_CHECK;
          end
          S_CHECK: begin
            if (!dec_flags.owned || dec_len_bad) begin
              ev_err <= 1'b1;
              state  <= S_IDLE;
            end else begin
              cmd_valid <= 1'b1;
              cmd_q     <= dec_cmd;
              cmd_addr  <= AW'(buf_word);
              next_q    <= AW'(next_word);
              last_q    <= dec_flags.last;
              bd_ie_q   <= dec_flags.ie_bd;
              pkt_q     <= dec_flags.ie_pkt && dec_flags.pkt_end;
              state     <= S_ISSUE;
            end
          end
          S_ISSUE: begin
            if (cmd_ready) begin
              cmd_valid <= 1'b0;
              state     <= S_WAIT;
            end
          end
          S_WAIT: begin
            if (eng_done) begin
              ev_bd_done  <= bd_ie_q;
              ev_pkt_done <= pkt_q;
              if (last_q || (next_q == '0)) begin
                state <= S_IDLE;
              end else begin
                cur_addr <= next_q;
                fetch_go <= 1'b1;
                state    <= S_FETCH;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  a_r12_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready && !stop_req) |=>
      (cmd_valid && $stable(cmd_q) && $stable(cmd_addr)));

  a_r11_stop_idle: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> (!busy && !cmd_valid));

  a_r4_err_no_cmd: assert property (@(posedge clk) disable iff (rst)
    ev_err |-> !cmd_valid);

  a_r6_evt_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_err, ev_bd_done || ev_pkt_done}));

  a_r10_last_ends: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && eng_done && last_q && !stop_req) |=> !busy);

  a_r9_null_next: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && eng_done && next_q == '0 && !stop_req) |=> !busy);

endmodule

// File: rtl/bd_chain_walker.sv
module bd_chain_walker
  import bdw_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LEN_MAX = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [2:0]        ctl_wdata,
  input  logic              base_wr,
  input  logic [AW-1:0]     base_wdata,
  output logic [AW-1:0]     cur_addr,
  output logic              busy,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_rx,
  output logic              cmd_ddr,
  output logic [1:0]        cmd_lanes,
  output logic              cmd_lsb_first,
  output logic              cmd_poll,
  output logic [1:0]        cmd_cs,
  output logic              cmd_cs_release,
  output logic [AW-1:0]     cmd_buf_addr,
  input  logic              eng_done,
  output logic              ev_bd_done,
  output logic              ev_pkt_done,
  output logic              ev_err
);

  localparam int DESC_BITS = DESC_WORDS * WORD_W;

  logic [AW-1:0]        base_q;
  logic                 fetch_go;
  logic                 fetch_abort;
  logic                 fetch_done;
  logic [DESC_BITS-1:0] desc_words;
  bdw_cmd_t             dec_cmd;
  bdw_flags_t           dec_flags;
  logic                 dec_len_bad;
  bdw_cmd_t             cmd_q;

  always_ff @(posedge clk) begin
    if (rst)          base_q <= '0;
    else if (base_wr) base_q <= base_wdata;
  end

  bdw_fetch #(
    .AW(AW), .DW(WORD_W), .WORDS(DESC_WORDS)
  ) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .go         (fetch_go),
    .abort      (fetch_abort),
    .start_addr (cur_addr),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .words      (desc_words),
    .done       (fetch_done)
  );

  bdw_decode #(
    .LEN_MAX(LEN_MAX)
  ) u_decode (
    .ctrl_word (desc_words[W_CTRL*WORD_W +: WORD_W]),
    .cmd       (dec_cmd),
    .flags     (dec_flags),
    .len_bad   (dec_len_bad)
  );

  bdw_seq #(
    .AW(AW)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (ctl_wdata),
    .base_addr   (base_q),
    .fetch_done  (fetch_done),
    .dec_cmd     (dec_cmd),
    .dec_flags   (dec_flags),
    .dec_len_bad (dec_len_bad),
    .buf_word    (desc_words[W_BUF*WORD_W +: WORD_W]),
    .next_word   (desc_words[W_NEXT*WORD_W +: WORD_W]),
    .cmd_ready   (cmd_ready),
    .eng_done    (eng_done),
    .fetch_go    (fetch_go),
    .fetch_abort (fetch_abort),
    .cur_addr    (cur_addr),
    .busy        (busy),
    .cmd_valid   (cmd_valid),
    .cmd_q       (cmd_q),
    .cmd_addr    (cmd_buf_addr),
    .ev_bd_done  (ev_bd_done),
    .ev_pkt_done (ev_pkt_done),
    .ev_err      (ev_err)
  );

  // The status word is fetched to keep the four-word layout but carries nothing used here.
  logic unused_status;
  assign unused_status = ^desc_words[W_STAT*WORD_W +: WORD_W];

  assign cmd_len        = cmd_q.len;
  assign cmd_rx         = cmd_q.rx;
  assign cmd_ddr        = cmd_q.ddr;
  assign cmd_lanes      = cmd_q.lanes;
  assign cmd_lsb_first  = cmd_q.lsb_first;
  assign cmd_poll       = cmd_q.poll;
  assign cmd_cs         = cmd_q.cs;
  assign cmd_cs_release = cmd_q.cs_release;

endmodule

// File: tb/bd_chain_walker_test.sv
`timescale 1ns/1ps
module bd_chain_walker_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 1'b0;
  logic [2:0]  ctl_wdata = 3'b000;
  logic        base_wr = 1'b0;
  logic [31:0] base_wdata = '0;
  logic [31:0] cur_addr;
  logic        busy;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b1;
  logic [8:0]  cmd_len;
  logic        cmd_rx, cmd_ddr, cmd_lsb_first, cmd_poll, cmd_cs_release;
  logic [1:0]  cmd_lanes, cmd_cs;
  logic [31:0] cmd_buf_addr;
  logic        eng_done = 1'b0;
  logic        ev_bd_done, ev_pkt_done, ev_err;

  always #5 clk = ~clk;

  bd_chain_walker uut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .base_wr(base_wr), .base_wdata(base_wdata), .cur_addr(cur_addr), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_len(cmd_len), .cmd_rx(cmd_rx),
    .cmd_ddr(cmd_ddr), .cmd_lanes(cmd_lanes), .cmd_lsb_first(cmd_lsb_first),
    .cmd_poll(cmd_poll), .cmd_cs(cmd_cs), .cmd_cs_release(cmd_cs_release),
    .cmd_buf_addr(cmd_buf_addr), .eng_done(eng_done),
    .ev_bd_done(ev_bd_done), .ev_pkt_done(ev_pkt_done), .ev_err(ev_err)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  // Behavioural memory: 64 words, two negedges of latency.
  logic [31:0] mem [64];
  int          lat_cnt = 0;
  logic [31:0] pend_addr = '0;
  int          n_req = 0;
  logic [31:0] req_log [64];

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (lat_cnt > 0) begin
      lat_cnt = lat_cnt - 1;
      if (lat_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[pend_addr[7:2]];
      end
    end
    if (mem_req) begin
      pend_addr = mem_addr;
      lat_cnt   = 2;
      if (n_req < 64) req_log[n_req] = mem_addr;
      n_req = n_req + 1;
    end
  end

  // Serial engine model: logs each accepted command, done three negedges later.
  int          eng_cnt = 0;
  int          n_cmd = 0;
  logic [17:0] cmd_log [16];
  logic [31:0] addr_log [16];

  always @(negedge clk) begin
    eng_done = 1'b0;
    if (eng_cnt > 0) begin
      eng_cnt = eng_cnt - 1;
      if (eng_cnt == 0) eng_done = 1'b1;
    end
    if (cmd_valid && cmd_ready) begin
      if (n_cmd < 16) begin
        cmd_log[n_cmd]  = {cmd_cs_release, cmd_cs, cmd_poll, cmd_lsb_first,
                           cmd_lanes, cmd_ddr, cmd_rx, cmd_len};
        addr_log[n_cmd] = cmd_buf_addr;
      end
      n_cmd   = n_cmd + 1;
      eng_cnt = 3;
    end
  end

  int n_bd = 0, n_pkt = 0, n_err = 0;
  always @(negedge clk) begin
    if (ev_bd_done)  n_bd  = n_bd + 1;
    if (ev_pkt_done) n_pkt = n_pkt + 1;
    if (ev_err)      n_err = n_err + 1;
  end

  // Vector table. Expected bits: [8:0] len, [9] rx, [10] ddr, [12:11] lanes,
  // [13] lsb, [14] poll, [16:15] cs, [17] release, [18] bd event, [19] pkt event, [20] error.
  localparam int NV = 7;
  localparam logic [31:0] VCTRL [NV] = '{
    32'h8008_0010, 32'h8299_0100, 32'hE8EE_0001, 32'h904A_0020,
    32'h0009_0010, 32'h8008_0101, 32'h800D_0040 };
  localparam logic [20:0] VEXP [NV] = '{
    21'h00010, 21'h43300, 21'hB5401, 21'h08820,
    21'h100000, 21'h100000, 21'h40040 };
  localparam string VREQ [NV] = '{"R3", "R3", "R7", "R7", "R4", "R5", "R6"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [2:0] v);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = 3'b000;
  endtask

  task automatic base_write(input logic [31:0] a);
    @(negedge clk);
    base_wr = 1'b1; base_wdata = a;
    @(negedge clk);
    base_wr = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] c,
                          input logic [31:0] b, input logic [31:0] nx);
    mem[a[7:2]]     = c;
    mem[a[7:2] + 1] = 32'h0;
    mem[a[7:2] + 2] = b;
    mem[a[7:2] + 3] = nx;
  endtask

  task automatic wait_idle;
    cycles(2);
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
    cycles(3);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    cycles(3);
    rst = 1'b0;
    cycles(1);

    // R1: reset state
    chk("R1", {28'h0, busy, mem_req, cmd_valid, ev_err}, 32'h0);
    chk("R1", {29'h0, ev_bd_done, ev_pkt_done, 1'b0}, 32'h0);
    chk("R1", cur_addr, 32'h0);

    // Vector walk: one descriptor at 0x40, a bait descriptor at 0x80 after it.
    base_write(32'h40);
    for (int i = 0; i < NV; i++) begin
      int c0, b0, p0, e0;
      logic [20:0] ex;
      ex = VEXP[i];
      put_desc(32'h40, VCTRL[i], 32'h1000 + i * 32'h100, 32'h80);
      put_desc(32'h80, 32'h8008_0004, 32'hDEAD_0000, 32'h0);
      c0 = n_cmd; b0 = n_bd; p0 = n_pkt; e0 = n_err;
      ctl_write(3'b111);
      wait_idle();
      // R10: bit 19 set, the bait at 0x80 is never followed
      chk(VREQ[i], n_cmd - c0, ex[20] ? 0 : 1);
      if (!ex[20] && c0 < 16) begin
        chk(VREQ[i], {14'h0, cmd_log[c0]}, {14'h0, ex[17:0]});
        chk("R3", addr_log[c0], 32'h1000 + i * 32'h100);
      end
      chk(VREQ[i], n_bd - b0, {31'h0, ex[18]});
      chk(VREQ[i], n_pkt - p0, {31'h0, ex[19]});
      chk(VREQ[i], n_err - e0, {31'h0, ex[20]});
      chk("R10", cur_addr, 32'h40);
    end

    // R2: a control write without start does nothing
    begin
      int r0;
      r0 = n_req;
      ctl_write(3'b101);
      cycles(6);
      chk("R2", {31'h0, busy}, 32'h0);
      chk("R2", n_req - r0, 0);
    end

    // R8 / R9 / R2: three-descriptor chain ending on a null pointer
    begin
      int c0, b0, p0, r0;
      put_desc(32'h10, 32'h8001_0008, 32'h2000, 32'h50);
      put_desc(32'h50, 32'h8041_0010, 32'h2100, 32'h90);
      put_desc(32'h90, 32'hC006_0004, 32'h2200, 32'h0);
      base_write(32'h10);
      c0 = n_cmd; b0 = n_bd; p0 = n_pkt; r0 = n_req;
      ctl_write(3'b111);
      for (int k = 0; k < 2000 && n_cmd < c0 + 2; k++) @(negedge clk);
      chk("R8", cur_addr, 32'h50);
      wait_idle();
      chk("R9", n_cmd - c0, 3);
      chk("R2", n_req - r0, 12);
      if (r0 + 4 <= 64) begin
        chk("R2", req_log[r0],     32'h10);
        chk("R2", req_log[r0 + 1], 32'h14);
        chk("R2", req_log[r0 + 3], 32'h1C);
        chk("R8", req_log[r0 + 4], 32'h50);
      end
      if (c0 + 3 <= 16) begin
        chk("R8", addr_log[c0 + 1], 32'h2100);
        chk("R8", {14'h0, cmd_log[c0 + 1]}, 32'h00810);
        chk("R3", {14'h0, cmd_log[c0 + 2]}, 32'h20004);
      end
      chk("R6", n_bd - b0, 2);
      chk("R7", n_pkt - p0, 1);
      chk("R9", cur_addr, 32'h90);
    end

    // R12: command held while the engine stalls, accepted once
    begin
      int c0;
      logic [8:0] len0;
      put_desc(32'h10, 32'h8008_0021, 32'h3000, 32'h0);
      base_write(32'h10);
      cmd_ready = 1'b0;
      c0 = n_cmd;
      ctl_write(3'b111);
      for (int k = 0; k < 2000 && !cmd_valid; k++) @(negedge clk);
      len0 = cmd_len;
      cycles(6);
      chk("R12", {31'h0, cmd_valid}, 32'h1);
      chk("R12", {23'h0, cmd_len}, {23'h0, len0});
      chk("R12", {23'h0, len0}, 32'h21);
      cmd_ready = 1'b1;
      wait_idle();
      chk("R12", n_cmd - c0, 1);
    end

    // R11: stop while a command is offered
    begin
      int c0;
      cmd_ready = 1'b0;
      c0 = n_cmd;
      ctl_write(3'b111);
      for (int k = 0; k < 2000 && !cmd_valid; k++) @(negedge clk);
      ctl_write(3'b000);
      cycles(1);
      chk("R11", {30'h0, busy, cmd_valid}, 32'h0);
      cmd_ready = 1'b1;
      cycles(10);
      chk("R11", n_cmd - c0, 0);
      chk("R11", {31'h0, busy}, 32'h0);
    end

    // R13: second start while busy is ignored
    begin
      int c0;
      put_desc(32'h10, 32'h8008_0008, 32'h3100, 32'h50);
      put_desc(32'h90, 32'h8008_0008, 32'h3900, 32'h0);
      base_write(32'h10);
      c0 = n_cmd;
      ctl_write(3'b111);
      base_write(32'h90);
      ctl_write(3'b111);
      wait_idle();
      cycles(10);
      chk("R13", n_cmd - c0, 1);
      if (c0 < 16) chk("R13", addr_log[c0], 32'h3100);
      chk("R13", cur_addr, 32'h10);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

endmodule